// File: doc/BRIEF.md
# Programmable Logic Output Macrocell Bank

This block is a bank of sixteen output cells of the kind found at the back end of a small programmable logic device. Each cell takes a group of product terms from an AND array and ORs them into a single sum. A cell can also give its own terms away to the cells on either side, or take terms that a neighbour gives away. An XOR stage with a per-cell polarity bit can invert the sum. The result then either drives the cell output directly or is captured in a D flip-flop that has its own clock, preset and clear.

The flip-flop clock comes from the cell's own product-term clock or from a shared global clock input. Both are sampled on the single system clock, and each rising edge is detected as a one-cycle load. Product-term preset and clear are level-sensitive and active high. Clear beats preset, and both beat a clock edge. A processor port can load any cell's flip-flop with a data bit in one cycle through a per-cell write strobe. That load overrides preset, clear and clock. Each cell output appears at the same moment on the pin output, the processor read word and the feedback bus.

A configuration register sits beside each cell and is written through a per-cell strobe with a shared 6-bit word. Its encoding is given in the requirements.

Top module: `omc_bank`

## Requirements
- R1: While reset is active and after it is released, every flip-flop and every configuration register holds 0. With all product terms low, all three outputs read 0.
- R2: With configuration bit 1 (bypass) set, a cell output equals the OR of its four native product terms, XOR its polarity bit, in the same cycle as the terms change.
- R3: Configuration bit 0 (polarity) inverts the summed product terms, both in bypass mode and in what a registered cell captures.
- R4: A cell with configuration bit 3 (lend) set leaves its own native terms out of its own sum.
- R5: Configuration bit 4 adds the native terms of cell i-1, and bit 5 adds those of cell i+1, indices taken modulo 16. A neighbour's terms are added only while that neighbour has its lend bit set.
- R6: With bit 1 clear and bit 2 clear, a cell captures its polarity-adjusted sum on the system clock edge after its product-term clock goes from 0 to 1. A clock held high, or held low, leaves the stored value unchanged.
- R7: With configuration bit 2 set, the cell captures only on rising edges of the global clock input and ignores its product-term clock.
- R8: Without a processor write, an active clear forces the stored bit to 0 on the next system clock edge, even when preset is also active. An active preset alone forces it to 1. Both take priority over a clock edge.
- R9: A processor write strobe for a cell loads that cell's data bit on the next system clock edge, whatever preset, clear and clock are doing.
- R10: For every cell, the pin output, the processor read word bit and the feedback bus bit always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_native | input | 64 | Native product terms, four per cell, cell i at bits 4i+3..4i |
| pt_clk | input | 16 | Product-term clock per cell |
| pt_pre | input | 16 | Product-term preset per cell, active high |
| pt_clr | input | 16 | Product-term clear per cell, active high |
| gclk_in | input | 1 | Shared global clock input |
| cfg_we | input | 16 | Per-cell configuration write strobe |
| cfg_wdata | input | 6 | Configuration word: bit0 polarity, bit1 bypass, bit2 global clock, bit3 lend, bit4 borrow low, bit5 borrow high |
| cpu_we | input | 16 | Per-cell processor write strobe |
| cpu_wdata | input | 16 | Processor write data, one bit per cell |
| pin_out | output | 16 | Cell outputs to the pin path |
| cpu_rdata | output | 16 | Cell outputs as the processor read word |
| fb_out | output | 16 | Cell outputs to the feedback bus |

## Verification
The processor load can land in the same system cycle as a product-term clear, a preset or a detected clock edge on the same cell. The bench provokes this by raising the write strobe while clear is held. In a separate case it raises the strobe on the exact cycle the product-term clock rises, with a data bit opposite to the sum that would be captured. In both cases it judges from the cell output one cycle later that the written bit, and only the written bit, was stored. It also holds preset and clear together to check that clear wins.

// File: rtl/omc_pkg.sv
package omc_pkg;

  localparam int CFG_W = 6;

  typedef struct packed {
    logic borrow_hi;
    logic borrow_lo;
    logic lend;
    logic gsel;
    logic bypass;
    logic pol;
  } omc_cfg_t;

  // Polarity-adjusted sum of own and borrowed terms
  function automatic logic term_sum(
    input logic own_any,
    input logic lo_any,
    input logic hi_any,
    input logic own_lend,
    input logic lo_lend,
    input logic hi_lend,
    input logic take_lo,
    input logic take_hi,
    input logic pol
  );
    logic s;
    s = (own_any & ~own_lend)
      | (lo_any & lo_lend & take_lo)
      | (hi_any & hi_lend & take_hi);
    return s ^ pol;
  endfunction

  // Flip-flop next state: write > clear > preset > edge > hold
  function automatic logic ff_next(
    input logic q,
    input logic wr,
    input logic wbit,
    input logic clr,
    input logic pre,
    input logic edge_hit,
    input logic d
  );
    if (wr)            return wbit;
    else if (clr)      return 1'b0;
    else if (pre)      return 1'b1;
    else if (edge_hit) return d;
    else               return q;
  endfunction

endpackage

// File: rtl/omc_cfg_bank.sv
module omc_cfg_bank
  import omc_pkg::*;
#(
  parameter int NCELL = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCELL-1:0]       cfg_we,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [NCELL*CFG_W-1:0] cfg_flat
);

  genvar gi;
  generate
    for (gi = 0; gi < NCELL; gi++) begin : g_cfg
      logic [CFG_W-1:0] cfg_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '0;
        else if (cfg_we[gi]) cfg_q <= cfg_wdata;
      end
      assign cfg_flat[gi*CFG_W +: CFG_W] = cfg_q;
    end
  endgenerate

endmodule

// File: rtl/omc_term_sum.sv
module omc_term_sum
  import omc_pkg::*;
#(
  parameter int NPT = 4
) (
  input  logic [NPT-1:0] nat_own,
  input  logic [NPT-1:0] nat_lo,
  input  logic [NPT-1:0] nat_hi,
  input  logic           own_lend,
  input  logic           lo_lend,
  input  logic           hi_lend,
  input  logic           take_lo,
  input  logic           take_hi,
  input  logic           pol,
  output logic           sum_out
);

  logic own_any, lo_any, hi_any;
  assign own_any = |nat_own;
  assign lo_any  = |nat_lo;
  assign hi_any  = |nat_hi;

  assign sum_out = term_sum(own_any, lo_any, hi_any, own_lend, lo_lend,
                            hi_lend, take_lo, take_hi, pol);

  // A lending cell that takes nothing shows only its polarity
  always_comb begin
    if (own_lend === 1'b1 && take_lo === 1'b0 && take_hi === 1'b0 &&
        pol !== 1'bx)
      assert_lend_empty_R4: assert (sum_out == pol);
  end

endmodule

// File: rtl/omc_cell_reg.sv
module omc_cell_reg
  import omc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pt_clk,
  input  logic gclk_rise,
  input  logic gsel,
  input  logic bypass,
  input  logic pt_pre,
  input  logic pt_clr,
  input  logic cpu_wr,
  input  logic cpu_bit,
  input  logic d_in,
  output logic cell_out
);

  logic q;
  logic ptclk_prev;
  logic ptclk_rise;
  logic take_edge;

  assign ptclk_rise = pt_clk & ~ptclk_prev;
  assign take_edge  = gsel ? gclk_rise : ptclk_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q          <= 1'b0;
      ptclk_prev <= 1'b0;
    end else begin
      ptclk_prev <= pt_clk;
      q          <= ff_next(q, cpu_wr, cpu_bit, pt_clr, pt_pre, take_edge, d_in);
    end
  end

  assign cell_out = bypass ? d_in : q;

  assert_cpu_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (q == $past(cpu_bit)));

  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && pt_clr) |=> !q);

  assert_pre_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && !pt_clr && pt_pre) |=> q);

  assert_edge_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && !pt_clr && !pt_pre && take_edge) |=> (q == $past(d_in)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && !pt_clr && !pt_pre && !take_edge) |=> $stable(q));

endmodule

// File: rtl/omc_bank.sv
module omc_bank
  import omc_pkg::*;
#(
  parameter int NCELL = 16,
  parameter int NPT   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCELL*NPT-1:0] pt_native,
  input  logic [NCELL-1:0]     pt_clk,
  input  logic [NCELL-1:0]     pt_pre,
  input  logic [NCELL-1:0]     pt_clr,
  input  logic                 gclk_in,
  input  logic [NCELL-1:0]     cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [NCELL-1:0]     cpu_we,
  input  logic [NCELL-1:0]     cpu_wdata,
  output logic [NCELL-1:0]     pin_out,
  output logic [NCELL-1:0]     cpu_rdata,
  output logic [NCELL-1:0]     fb_out
);

  localparam int CFG_BITS = NCELL * CFG_W;

  logic [CFG_BITS-1:0] cfg_flat;
  logic [NCELL-1:0]    cell_out;
  logic [NCELL-1:0]    lend_vec;
  logic                gclk_prev;
  logic                gclk_rise;

  omc_cfg_bank #(.NCELL(NCELL)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_flat (cfg_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gclk_prev <= 1'b0;
    else        gclk_prev <= gclk_in;
  end
  assign gclk_rise = gclk_in & ~gclk_prev;

  genvar gi;
  generate
    for (gi = 0; gi < NCELL; gi++) begin : g_cell
      localparam int LO = (gi + NCELL - 1) % NCELL;
      localparam int HI = (gi + 1) % NCELL;

      omc_cfg_t cfg;
      logic     sum_x;

      assign cfg          = omc_cfg_t'(cfg_flat[gi*CFG_W +: CFG_W]);
      assign lend_vec[gi] = cfg.lend;

      omc_term_sum #(.NPT(NPT)) u_sum (
        .nat_own (pt_native[gi*NPT +: NPT]),
        .nat_lo  (pt_native[LO*NPT +: NPT]),
        .nat_hi  (pt_native[HI*NPT +: NPT]),
        .own_lend(cfg.lend),
        .lo_lend (lend_vec[LO]),
        .hi_lend (lend_vec[HI]),
        .take_lo (cfg.borrow_lo),
        .take_hi (cfg.borrow_hi),
        .pol     (cfg.pol),
        .sum_out (sum_x)
      );

      omc_cell_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pt_clk   (pt_clk[gi]),
        .gclk_rise(gclk_rise),
        .gsel     (cfg.gsel),
        .bypass   (cfg.bypass),
        .pt_pre   (pt_pre[gi]),
        .pt_clr   (pt_clr[gi]),
        .cpu_wr   (cpu_we[gi]),
        .cpu_bit  (cpu_wdata[gi]),
        .d_in     (sum_x),
        .cell_out (cell_out[gi])
      );
    end
  endgenerate

  assign pin_out   = cell_out;
  assign cpu_rdata = cell_out;
  assign fb_out    = cell_out;

endmodule

// File: tb/test_omc_bank.sv
module test_omc_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pt_native;
  logic [15:0] pt_clk, pt_pre, pt_clr, cfg_we, cpu_we, cpu_wdata;
  logic        gclk_in;
  logic [5:0]  cfg_wdata;
  logic [15:0] pin_out, cpu_rdata, fb_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  omc_bank i_omc_bank (
    .clk(clk), .rst_n(rst_n), .pt_native(pt_native), .pt_clk(pt_clk),
    .pt_pre(pt_pre), .pt_clr(pt_clr), .gclk_in(gclk_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .pin_out(pin_out), .cpu_rdata(cpu_rdata), .fb_out(fb_out)
  );

  // {cfg1[5:0], lend0, lend2, nat0, nat1, nat2, expected out1}
  localparam logic [20:0] VEC [10] = '{
    {6'h02, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0},  // R2 all low
    {6'h02, 1'b0, 1'b0, 4'h0, 4'h4, 4'h0, 1'b1},  // R2 one term
    {6'h03, 1'b0, 1'b0, 4'h0, 4'h4, 4'h0, 1'b0},  // R3 inverted
    {6'h03, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1},  // R3 inverted zero
    {6'h0A, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0, 1'b0},  // R4 own terms lent
    {6'h12, 1'b1, 1'b0, 4'h1, 4'h0, 4'h0, 1'b1},  // R5 borrow low
    {6'h12, 1'b0, 1'b0, 4'h1, 4'h0, 4'h0, 1'b0},  // R5 low not lending
    {6'h22, 1'b0, 1'b1, 4'h0, 4'h0, 4'h8, 1'b1},  // R5 borrow high
    {6'h22, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 1'b0},  // R5 high terms low
    {6'h33, 1'b1, 1'b1, 4'h2, 4'h0, 4'h0, 1'b0}   // R5 R3 both + pol
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input int idx, input logic [5:0] v);
    cfg_we    = 16'h0001 << idx;
    cfg_wdata = v;
    step();
    cfg_we    = '0;
  endtask

  // R10: every output path agrees with the expected value
  task automatic check_cell(input int idx, input logic exp, input string req);
    check(pin_out[idx], exp, req);
    check(cpu_rdata[idx], exp, {req, " R10 read"});
    check(fb_out[idx], exp, {req, " R10 feedback"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pt_native = '0; pt_clk = '0; pt_pre = '0; pt_clr = '0;
    gclk_in = 1'b0; cfg_we = '0; cfg_wdata = '0; cpu_we = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    check(cpu_rdata == 16'h0, 1'b1, "R1 outputs cleared");
    pt_native[7:4] = 4'hF; #2;
    check(pin_out[1], 1'b0, "R1 config cleared, still registered");
    pt_native = '0;

    for (int k = 0; k < 10; k++) begin
      logic [20:0] v;
      v = VEC[k];
      wr_cfg(0, v[14] ? 6'h0A : 6'h02);
      wr_cfg(2, v[13] ? 6'h0A : 6'h02);
      wr_cfg(1, v[20:15]);
      pt_native[3:0]  = v[12:9];
      pt_native[7:4]  = v[8:5];
      pt_native[11:8] = v[4:1];
      #2;
      check_cell(1, v[0], $sformatf("R2 R3 R4 R5 vector %0d", k));
    end
    pt_native = '0;
    wr_cfg(0, 6'h00); wr_cfg(1, 6'h00); wr_cfg(2, 6'h00);

    // R5 wrap: cell 0 borrows from cell 15
    wr_cfg(15, 6'h08);
    wr_cfg(0, 6'h12);
    pt_native[63:60] = 4'h1; #2;
    check_cell(0, 1'b1, "R5 wrap borrow");
    pt_native = '0;
    wr_cfg(15, 6'h00); wr_cfg(0, 6'h00);

    // R6 product-term clock on cell 3
    pt_native[15:12] = 4'h2; pt_clk[3] = 1'b1;
    step();
    check_cell(3, 1'b1, "R6 capture on rise");
    pt_native[15:12] = 4'h0;
    step();
    check(pin_out[3], 1'b1, "R6 hold while clock high");
    pt_clk[3] = 1'b0; step();
    check(pin_out[3], 1'b1, "R6 hold on fall");
    pt_clk[3] = 1'b1; step();
    check(pin_out[3], 1'b0, "R6 capture zero");

    // R8 preset and clear
    pt_pre[3] = 1'b1; step();
    check(pin_out[3], 1'b1, "R8 preset");
    pt_clr[3] = 1'b1; step();
    check(pin_out[3], 1'b0, "R8 clear beats preset");
    pt_pre[3] = 1'b0;

    // R9 write beats held clear
    cpu_we[3] = 1'b1; cpu_wdata[3] = 1'b1; step();
    check(pin_out[3], 1'b1, "R9 write over clear");
    cpu_we[3] = 1'b0; step();
    check(pin_out[3], 1'b0, "R8 clear after write");
    pt_clr[3] = 1'b0;

    // R9 write beats a clock edge in the same cycle
    pt_native[15:12] = 4'hF; pt_clk[3] = 1'b0; step();
    pt_clk[3] = 1'b1; cpu_we[3] = 1'b1; cpu_wdata[3] = 1'b0; step();
    check(pin_out[3], 1'b0, "R9 write over clock edge");
    cpu_we[3] = 1'b0;

    // R7 global clock
    wr_cfg(3, 6'h04);
    pt_clk[3] = 1'b0; step();
    pt_clk[3] = 1'b1; step();
    check(pin_out[3], 1'b0, "R7 product-term clock ignored");
    gclk_in = 1'b1; step();
    check(pin_out[3], 1'b1, "R7 global clock capture");
    pt_native[15:12] = 4'h0; step();
    check(pin_out[3], 1'b1, "R7 global clock held high");
    gclk_in = 1'b0;

    // R3 polarity in registered mode
    wr_cfg(3, 6'h01);
    pt_clk[3] = 1'b0; step();
    pt_clk[3] = 1'b1; step();
    check_cell(3, 1'b1, "R3 registered polarity");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule